// File: doc/BRIEF.md
# Single-Bit Shifter with Selectable Fill

This block performs a one-position shift of a 16-bit operand in a microprogrammed datapath. A 4-bit direction/fill code picks the direction (toward the MSB or toward the LSB) and the bit that enters the vacated position. That bit can be a constant 0, a constant 1, the link flag, the carry flag, or the XOR of the negative and overflow flags. The operand comes from a register-file word, the accumulator or the external data input. A write strobe steers the result to the register file, the accumulator or the output bus.

There are two instruction forms. In the register form, the result is written back to the register file, and the operand is the register word or the data input. In the non-register form, the operand is the accumulator or the data input, and the result goes to the output bus or the accumulator. A mode bit limits the shift to the low byte. The unit reports the bit that left the lane and updates the link, negative and zero flags. An operation is accepted on a cycle with `op_valid` high, and its results appear on the registered outputs one clock later.

Top module: `fill_shifter`

## Requirements
- R1: Codes 0, 1 and 2 shift toward the MSB. Bit 0 receives 0, 1 or the link flag (`flag_link`) respectively.
- R2: Codes 4, 5 and 6 shift toward the LSB. The lane MSB receives 0, 1 or the link flag respectively.
- R3: Code 7 shifts toward the LSB and fills the lane MSB with the carry flag. Code 8 does the same with `flag_n XOR flag_ovr` as the fill.
- R4: With `word_mode` = 0 only bits 7:0 shift. The fill enters bit 7 on a downward shift and bit 0 on an upward shift, and bits 15:8 pass through unchanged. With `word_mode` = 1 all 16 bits shift.
- R5: `shift_out` is the bit that left the lane: the lane MSB (bit 15 or bit 7) for an upward shift, and bit 0 for a downward shift. On a legal operation `link_out` equals `shift_out`.
- R6: On a legal operation, `n_out` is the lane MSB of the result. `z_out` is 1 exactly when the lane (16 bits, or bits 7:0 in byte mode) of the result is zero.
- R7: With `reg_form` = 1, source code 6 selects `reg_rd` and source code 7 selects `d_in`. A legal operation pulses `reg_we`.
- R8: With `reg_form` = 0, source code 6 selects `acc_rd` and source code 7 selects `d_in`. Destination code 0 pulses `bus_oe` and destination code 1 pulses `acc_we`. At most one strobe is high in any cycle.
- R9: Illegal operations are codes 3 and 9 to 15, a source code other than 6 or 7, and (in the non-register form) a destination code other than 0 or 1. For these, `illegal` is 1, `y_out` equals the operand unchanged, no strobe pulses, `shift_out` is 0, and `link_out`, `n_out` and `z_out` copy `flag_link`, `flag_n` and `flag_z`. When the source code is illegal, the operand is `d_in`.
- R10: All outputs update on the clock edge after `op_valid` is sampled high. Strobes last one cycle. While `op_valid` is low, the strobes are 0 and every other output holds its value.
- R11: An active-low reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| word_mode | input | 1 | 1 = 16-bit lane, 0 = low-byte lane |
| reg_form | input | 1 | 1 = register-destination form |
| src_sel | input | 4 | Operand source code (6 or 7) |
| dst_sel | input | 4 | Non-register destination code (0 bus, 1 accumulator) |
| dir_fill | input | 4 | Direction/fill code |
| reg_rd | input | 16 | Register-file operand word |
| acc_rd | input | 16 | Accumulator operand word |
| d_in | input | 16 | External data input |
| flag_z | input | 1 | Current zero flag |
| flag_n | input | 1 | Current negative flag |
| flag_ovr | input | 1 | Current overflow flag |
| flag_c | input | 1 | Current carry flag |
| flag_link | input | 1 | Current link flag |
| y_out | output | 16 | Shift result |
| reg_we | output | 1 | Register-file write strobe |
| acc_we | output | 1 | Accumulator write strobe |
| bus_oe | output | 1 | Output-bus drive strobe |
| shift_out | output | 1 | Bit that left the lane |
| link_out | output | 1 | Updated link flag |
| n_out | output | 1 | Updated negative flag |
| z_out | output | 1 | Updated zero flag |
| illegal | output | 1 | Operation rejected |

## Verification
The hardest situations to reach are those where byte and word behaviour differ. One is a byte-mode result whose low byte is zero while the whole word is not; another is a downward byte shift whose fill lands in bit 7 and never in bit 15. The vector table includes operands with a nonzero upper byte for these cases. It also drives the two operand inputs that are not selected with distinct values, so a wrong source choice shows up in `y_out`. For the code-8 fill, the table uses both flag pairs that differ in their XOR, in word and in byte mode. Illegal codes are given flag inputs that differ from any shift outcome, so a flag that is not passed through is visible.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  // Direction/fill codes: the encoding is the instruction's contract.
  localparam logic [3:0] DF_UP_ZERO  = 4'd0;
  localparam logic [3:0] DF_UP_ONE   = 4'd1;
  localparam logic [3:0] DF_UP_LINK  = 4'd2;
  localparam logic [3:0] DF_DN_ZERO  = 4'd4;
  localparam logic [3:0] DF_DN_ONE   = 4'd5;
  localparam logic [3:0] DF_DN_LINK  = 4'd6;
  localparam logic [3:0] DF_DN_CARRY = 4'd7;
  localparam logic [3:0] DF_DN_NXV   = 4'd8;

  // Operand source and non-register destination codes.
  localparam logic [3:0] SRC_HOME = 4'd6;
  localparam logic [3:0] SRC_DATA = 4'd7;
  localparam logic [3:0] DST_BUS  = 4'd0;
  localparam logic [3:0] DST_ACC  = 4'd1;

  typedef enum logic [2:0] {
    FILL_ZERO,
    FILL_ONE,
    FILL_LINK,
    FILL_CARRY,
    FILL_NXV
  } fill_e;

  typedef struct packed {
    logic  legal;
    logic  down;
    fill_e fill;
  } shift_ctl_t;

  typedef struct packed {
    logic to_reg;
    logic to_acc;
    logic to_bus;
  } dest_t;

endpackage

// File: rtl/fsh_code_decode.sv
module fsh_code_decode
  import fsh_pkg::*;
(
  input  logic [3:0] code,
  output shift_ctl_t ctl
);

  always_comb begin
    ctl = '{legal: 1'b1, down: 1'b0, fill: FILL_ZERO};
    case (code)
      DF_UP_ZERO:  ctl = '{legal: 1'b1, down: 1'b0, fill: FILL_ZERO};
      DF_UP_ONE:   ctl = '{legal: 1'b1, down: 1'b0, fill: FILL_ONE};
      DF_UP_LINK:  ctl = '{legal: 1'b1, down: 1'b0, fill: FILL_LINK};
      DF_DN_ZERO:  ctl = '{legal: 1'b1, down: 1'b1, fill: FILL_ZERO};
      DF_DN_ONE:   ctl = '{legal: 1'b1, down: 1'b1, fill: FILL_ONE};
      DF_DN_LINK:  ctl = '{legal: 1'b1, down: 1'b1, fill: FILL_LINK};
      DF_DN_CARRY: ctl = '{legal: 1'b1, down: 1'b1, fill: FILL_CARRY};
      DF_DN_NXV:   ctl = '{legal: 1'b1, down: 1'b1, fill: FILL_NXV};
      default:     ctl = '{legal: 1'b0, down: 1'b0, fill: FILL_ZERO};
    endcase
  end

endmodule

// File: rtl/fsh_route.sv
module fsh_route
  import fsh_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              reg_form,
  input  logic [3:0]        src_sel,
  input  logic [3:0]        dst_sel,
  input  logic [DATA_W-1:0] reg_rd,
  input  logic [DATA_W-1:0] acc_rd,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] operand,
  output dest_t             dest,
  output logic              route_ok
);

  logic src_home;
  logic src_ok;
  logic dst_ok;

  assign src_home = (src_sel == SRC_HOME);
  assign src_ok   = src_home || (src_sel == SRC_DATA);
  assign dst_ok   = reg_form || (dst_sel == DST_BUS) || (dst_sel == DST_ACC);
  assign route_ok = src_ok && dst_ok;

  always_comb begin
    if (src_home) operand = reg_form ? reg_rd : acc_rd;
    else          operand = d_in;
  end

  always_comb begin
    dest = '0;
    if (reg_form)                 dest.to_reg = 1'b1;
    else if (dst_sel == DST_ACC)  dest.to_acc = 1'b1;
    else                          dest.to_bus = 1'b1;
  end

endmodule

// File: rtl/fsh_lane_shift.sv
module fsh_lane_shift
  import fsh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              word_mode,
  input  shift_ctl_t        ctl,
  input  logic              fl_n,
  input  logic              fl_ovr,
  input  logic              fl_c,
  input  logic              fl_link,
  output logic [DATA_W-1:0] result,
  output logic              bit_out,
  output logic              res_n,
  output logic              res_z
);

  localparam int UPPER_W = DATA_W - BYTE_W;

  function automatic logic pick_fill(input fill_e f, input logic n, input logic v,
                                     input logic c, input logic l);
    case (f)
      FILL_ONE:   return 1'b1;
      FILL_LINK:  return l;
      FILL_CARRY: return c;
      FILL_NXV:   return n ^ v;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] shift_word(input logic [DATA_W-1:0] v,
                                                   input logic down, input logic fb);
    return down ? {fb, v[DATA_W-1:1]} : {v[DATA_W-2:0], fb};
  endfunction

  function automatic logic [BYTE_W-1:0] shift_byte(input logic [BYTE_W-1:0] v,
                                                   input logic down, input logic fb);
    return down ? {fb, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], fb};
  endfunction

  logic              fill_bit;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] byte_res;
  logic              word_out;
  logic              byte_out;

  assign fill_bit = pick_fill(ctl.fill, fl_n, fl_ovr, fl_c, fl_link);
  assign word_res = shift_word(operand, ctl.down, fill_bit);
  assign word_out = ctl.down ? operand[0] : operand[DATA_W-1];
  assign byte_out = ctl.down ? operand[0] : operand[BYTE_W-1];

  generate
    if (UPPER_W > 0) begin : g_split
      assign byte_res = {operand[DATA_W-1:BYTE_W],
                         shift_byte(operand[BYTE_W-1:0], ctl.down, fill_bit)};
    end else begin : g_whole
      assign byte_res = word_res;
    end
  endgenerate

  always_comb begin
    if (!ctl.legal) begin
      result  = operand;
      bit_out = 1'b0;
    end else if (word_mode) begin
      result  = word_res;
      bit_out = word_out;
    end else begin
      result  = byte_res;
      bit_out = byte_out;
    end
  end

  assign res_n = word_mode ? result[DATA_W-1] : result[BYTE_W-1];
  assign res_z = word_mode ? (result == '0) : (result[BYTE_W-1:0] == '0);

endmodule

// File: rtl/fill_shifter.sv
module fill_shifter
  import fsh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              word_mode,
  input  logic              reg_form,
  input  logic [3:0]        src_sel,
  input  logic [3:0]        dst_sel,
  input  logic [3:0]        dir_fill,
  input  logic [DATA_W-1:0] reg_rd,
  input  logic [DATA_W-1:0] acc_rd,
  input  logic [DATA_W-1:0] d_in,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_ovr,
  input  logic              flag_c,
  input  logic              flag_link,
  output logic [DATA_W-1:0] y_out,
  output logic              reg_we,
  output logic              acc_we,
  output logic              bus_oe,
  output logic              shift_out,
  output logic              link_out,
  output logic              n_out,
  output logic              z_out,
  output logic              illegal
);

  shift_ctl_t        ctl;
  dest_t             dest;
  logic              route_ok;
  logic              op_ok;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] shifted;
  logic              lane_out;
  logic              lane_n;
  logic              lane_z;
  logic              out_vld_q;
  logic              mode_q;

  fsh_code_decode u_dec (
    .code (dir_fill),
    .ctl  (ctl)
  );

  fsh_route #(.DATA_W(DATA_W)) u_route (
    .reg_form (reg_form),
    .src_sel  (src_sel),
    .dst_sel  (dst_sel),
    .reg_rd   (reg_rd),
    .acc_rd   (acc_rd),
    .d_in     (d_in),
    .operand  (operand),
    .dest     (dest),
    .route_ok (route_ok)
  );

  fsh_lane_shift #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .operand   (operand),
    .word_mode (word_mode),
    .ctl       (ctl),
    .fl_n      (flag_n),
    .fl_ovr    (flag_ovr),
    .fl_c      (flag_c),
    .fl_link   (flag_link),
    .result    (shifted),
    .bit_out   (lane_out),
    .res_n     (lane_n),
    .res_z     (lane_z)
  );

  assign op_ok = ctl.legal && route_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out     <= '0;
      reg_we    <= 1'b0;
      acc_we    <= 1'b0;
      bus_oe    <= 1'b0;
      shift_out <= 1'b0;
      link_out  <= 1'b0;
      n_out     <= 1'b0;
      z_out     <= 1'b0;
      illegal   <= 1'b0;
      out_vld_q <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      out_vld_q <= op_valid;
      reg_we    <= op_valid && op_ok && dest.to_reg;
      acc_we    <= op_valid && op_ok && dest.to_acc;
      bus_oe    <= op_valid && op_ok && dest.to_bus;
      if (op_valid) begin
        mode_q  <= word_mode;
        illegal <= !op_ok;
        if (op_ok) begin
          y_out     <= shifted;
          shift_out <= lane_out;
          link_out  <= lane_out;
          n_out     <= lane_n;
          z_out     <= lane_z;
        end else begin
          y_out     <= operand;
          shift_out <= 1'b0;
          link_out  <= flag_link;
          n_out     <= flag_n;
          z_out     <= flag_z;
        end
      end
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(reg_we || acc_we || bus_oe)); // R9

  AST_ILLEGAL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && illegal) |-> (y_out == $past(operand))); // R9

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, acc_we, bus_oe})); // R8

  AST_LINK_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || acc_we || bus_oe) |-> (link_out == shift_out)); // R5

  AST_UPPER_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && !mode_q) |-> (y_out[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W]))); // R4

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && mode_q && !illegal) |-> (z_out == (y_out == '0))); // R6

  AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || acc_we || bus_oe) |-> out_vld_q); // R10

endmodule

// File: tb/fill_shifter_test.sv
module fill_shifter_test;

  typedef struct packed {
    logic [3:0]  rq;
    logic        rf;
    logic        wm;
    logic [3:0]  src;
    logic [3:0]  dst;
    logic [3:0]  code;
    logic [4:0]  fl;   // {z, n, ovr, c, link}
    logic [15:0] op;
    logic [15:0] ey;
    logic        eso;
    logic [2:0]  ewe;  // {reg, acc, bus}
    logic        eill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b1, 1'b1, 4'd6, 4'd0, 4'd0,  5'b00000, 16'h8001, 16'h0002, 1'b1, 3'b100, 1'b0}, // R1 up fill 0
    '{4'd1, 1'b1, 1'b1, 4'd7, 4'd0, 4'd1,  5'b00000, 16'h4000, 16'h8001, 1'b0, 3'b100, 1'b0}, // R1 up fill 1, R7 data
    '{4'd1, 1'b0, 1'b1, 4'd6, 4'd1, 4'd2,  5'b00001, 16'h1234, 16'h2469, 1'b0, 3'b010, 1'b0}, // R1 up link, R8 acc
    '{4'd2, 1'b0, 1'b1, 4'd7, 4'd0, 4'd4,  5'b00000, 16'h0003, 16'h0001, 1'b1, 3'b001, 1'b0}, // R2 down fill 0
    '{4'd2, 1'b1, 1'b1, 4'd6, 4'd0, 4'd5,  5'b00000, 16'h0002, 16'h8001, 1'b0, 3'b100, 1'b0}, // R2 down fill 1
    '{4'd2, 1'b1, 1'b1, 4'd6, 4'd0, 4'd6,  5'b00001, 16'h0000, 16'h8000, 1'b0, 3'b100, 1'b0}, // R2 down link
    '{4'd3, 1'b0, 1'b1, 4'd6, 4'd0, 4'd7,  5'b00010, 16'hFFFE, 16'hFFFF, 1'b0, 3'b001, 1'b0}, // R3 carry 1
    '{4'd3, 1'b0, 1'b1, 4'd6, 4'd0, 4'd7,  5'b00001, 16'h0001, 16'h0000, 1'b1, 3'b001, 1'b0}, // R3 carry 0
    '{4'd3, 1'b1, 1'b1, 4'd6, 4'd0, 4'd8,  5'b01000, 16'h0000, 16'h8000, 1'b0, 3'b100, 1'b0}, // R3 n^v = 1
    '{4'd3, 1'b1, 1'b1, 4'd6, 4'd0, 4'd8,  5'b01100, 16'h0000, 16'h0000, 1'b0, 3'b100, 1'b0}, // R3 n^v = 0
    '{4'd4, 1'b1, 1'b0, 4'd6, 4'd0, 4'd4,  5'b00000, 16'hABCD, 16'hAB66, 1'b1, 3'b100, 1'b0}, // R4 byte down
    '{4'd4, 1'b1, 1'b0, 4'd7, 4'd0, 4'd1,  5'b00000, 16'h12C0, 16'h1281, 1'b1, 3'b100, 1'b0}, // R4 byte up
    '{4'd4, 1'b0, 1'b0, 4'd6, 4'd1, 4'd5,  5'b00000, 16'hFF00, 16'hFF80, 1'b0, 3'b010, 1'b0}, // R4 fill at bit 7
    '{4'd6, 1'b1, 1'b0, 4'd6, 4'd0, 4'd0,  5'b00000, 16'h5580, 16'h5500, 1'b1, 3'b100, 1'b0}, // R6 byte zero
    '{4'd4, 1'b1, 1'b0, 4'd6, 4'd0, 4'd8,  5'b00100, 16'h0000, 16'h0080, 1'b0, 3'b100, 1'b0}, // R4 byte n^v
    '{4'd9, 1'b1, 1'b1, 4'd6, 4'd0, 4'd3,  5'b10001, 16'h1357, 16'h1357, 1'b0, 3'b000, 1'b1}, // R9 code 3
    '{4'd9, 1'b1, 1'b1, 4'd6, 4'd0, 4'd15, 5'b01000, 16'h8888, 16'h8888, 1'b0, 3'b000, 1'b1}, // R9 code 15
    '{4'd9, 1'b0, 1'b1, 4'd6, 4'd2, 4'd0,  5'b00000, 16'h4321, 16'h4321, 1'b0, 3'b000, 1'b1}, // R9 bad dest
    '{4'd9, 1'b1, 1'b1, 4'd5, 4'd0, 4'd0,  5'b10000, 16'h0F0F, 16'h0F0F, 1'b0, 3'b000, 1'b1}, // R9 bad source
    '{4'd5, 1'b0, 1'b1, 4'd7, 4'd0, 4'd2,  5'b00001, 16'h8000, 16'h0001, 1'b1, 3'b001, 1'b0}  // R5 link in/out
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        word_mode;
  logic        reg_form;
  logic [3:0]  src_sel;
  logic [3:0]  dst_sel;
  logic [3:0]  dir_fill;
  logic [15:0] reg_rd;
  logic [15:0] acc_rd;
  logic [15:0] d_in;
  logic        flag_z, flag_n, flag_ovr, flag_c, flag_link;
  logic [15:0] y_out;
  logic        reg_we, acc_we, bus_oe, shift_out, link_out, n_out, z_out, illegal;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fill_shifter uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .word_mode(word_mode),
    .reg_form(reg_form), .src_sel(src_sel), .dst_sel(dst_sel), .dir_fill(dir_fill),
    .reg_rd(reg_rd), .acc_rd(acc_rd), .d_in(d_in),
    .flag_z(flag_z), .flag_n(flag_n), .flag_ovr(flag_ovr), .flag_c(flag_c),
    .flag_link(flag_link), .y_out(y_out), .reg_we(reg_we), .acc_we(acc_we),
    .bus_oe(bus_oe), .shift_out(shift_out), .link_out(link_out), .n_out(n_out),
    .z_out(z_out), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    reg_rd    = 16'hA5A5;
    acc_rd    = 16'h5A5A;
    d_in      = 16'hC3C3;
    if (v.src == 4'd6) begin
      if (v.rf) reg_rd = v.op;
      else      acc_rd = v.op;
    end else begin
      d_in = v.op;
    end
    reg_form  = v.rf;
    word_mode = v.wm;
    src_sel   = v.src;
    dst_sel   = v.dst;
    dir_fill  = v.code;
    {flag_z, flag_n, flag_ovr, flag_c, flag_link} = v.fl;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 reset y", y_out, 16'h0000);
    chk("R11 reset strobes/flags", {8'h0, reg_we, acc_we, bus_oe, shift_out, link_out, n_out, z_out, illegal}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic en, ez, el;
      v = VECS[i];
      drive(v);
      op_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (v.eill) begin
        el = v.fl[0]; en = v.fl[3]; ez = v.fl[4];
      end else begin
        el = v.eso;
        en = v.wm ? v.ey[15] : v.ey[7];
        ez = v.wm ? (v.ey == 16'h0) : (v.ey[7:0] == 8'h0);
      end
      chk($sformatf("R%0d vec%0d y", v.rq, i), y_out, v.ey);
      chk($sformatf("R5 vec%0d shift_out", i), {15'h0, shift_out}, {15'h0, v.eso});
      chk($sformatf("R5 vec%0d link", i), {15'h0, link_out}, {15'h0, el});
      chk($sformatf("R6 vec%0d n,z", i), {14'h0, n_out, z_out}, {14'h0, en, ez});
      chk($sformatf("%s vec%0d strobes", v.rf ? "R7" : "R8", i),
          {13'h0, reg_we, acc_we, bus_oe}, {13'h0, v.ewe});
      chk($sformatf("R9 vec%0d illegal", i), {15'h0, illegal}, {15'h0, v.eill});
    end

    // R10: idle cycle holds results, strobes drop
    drive(VECS[1]);
    op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 issue y", y_out, 16'h8001);
    op_valid = 1'b0;
    drive(VECS[3]);
    d_in = 16'h7777;
    @(posedge clk); @(negedge clk);
    chk("R10 hold y", y_out, 16'h8001);
    chk("R10 strobes low", {13'h0, reg_we, acc_we, bus_oe}, 16'h0000);
    chk("R10 hold flags", {12'h0, shift_out, link_out, n_out, z_out}, 16'h0002);

    // R11: reset after activity clears everything
    drive(VECS[6]);
    op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mid reset y", y_out, 16'h0000);
    chk("R11 mid reset strobes/flags", {8'h0, reg_we, acc_we, bus_oe, shift_out, link_out, n_out, z_out, illegal}, 16'h0000);
    op_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule